// File: doc/BRIEF.md
# Simple Dual-Port RAM with Sleep Lockout

This block is a behavioural model of a simple dual-port memory. Port A only writes and port B only reads, and both ports run on one clock. The data width is set by a parameter, and writes and reads use the same width. The memory does not reset its contents. Each accepted read loads a read latch. An optional pipeline register can follow that latch. The pipeline register has its own clock enable and its own synchronous clear. A parameter chooses whether the clear or the enable has precedence on that register.

A sleep input puts the array into a low-power state. While the array is asleep, and while it is waking, it refuses every access. Waking takes two clock edges once sleep goes low. An enable raised at the wrong moment is dropped and sets a protocol flag. The flag stays set until the next reset. The array keeps its contents through sleep.

Top module: `sdp_sleep_ram`

## Requirements
- R1: `RD_WIDTH` accepts 0, 1, 2, 4, 9, 18, 36 or 72. With 0 the read port is unused and `rd_data` is a single bit held at 0.
- R2: While `rst_n` is low, the read latch and the output register load `RST_VAL` and `proto_err` clears. The array is not cleared.
- R3: With `OUT_REG` = 0, a read accepted at clock edge k shows on `rd_data` after edge k. The value holds until the next accepted read.
- R4: With `OUT_REG` = 1, read data reaches `rd_data` one edge later than in R3. The output register loads the latch only on an edge where `oreg_ce` is 1.
- R5: With `RST_PRIO` = clear-first, an edge with `oreg_rst` = 1 loads `RST_VAL` into the output register, whatever the value of `oreg_ce`.
- R6: With `RST_PRIO` = enable-first, `oreg_rst` loads `RST_VAL` only on an edge where `oreg_ce` = 1. With `oreg_ce` = 0 the register holds its value.
- R7: A write and a read to the same address on the same edge return the old word on the read side. The new word is seen on a later read.
- R8: An edge that samples `sleep` = 1 puts the array to sleep. Writes and reads on that edge, and on every edge while asleep, are ignored. Contents survive.
- R9: After sleep, the first two edges that sample `sleep` = 0 are wake-up edges and refuse accesses. The third such edge accepts them.
- R10: `proto_err` sets after any edge that ignores an enable (R8, R9). It also sets after an edge that samples `sleep` = 1 while awake if an enable was high on the edge before. Once set, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep | input | 1 | Power-down request |
| wr_en | input | 1 | Write enable, port A |
| wr_addr | input | $clog2(DEPTH) | Write address |
| wr_data | input | DW (RD_WIDTH, or 1 when 0) | Write word |
| rd_en | input | 1 | Read enable, port B |
| rd_addr | input | $clog2(DEPTH) | Read address |
| oreg_ce | input | 1 | Output register clock enable |
| oreg_rst | input | 1 | Output register synchronous clear |
| rd_data | output | DW | Read word |
| proto_err | output | 1 | Sticky access-protocol violation flag |

## Verification
The stall property for the latch-only build assumes that no read is accepted on an edge where `rd_en` is low, `sleep` is high, or the array is not awake. The other properties take any input sequence. The random phase of the bench keeps all enables low for one cycle before sleep and for the two wake-up edges. A violation therefore comes only from the directed cases that aim for one. `DEPTH` is taken to be a power of two, so random addresses always hit the array. All words are written before the first read, so read data is never undefined.

// File: rtl/sdp_pkg.sv
// Shared types for the sleep-capable dual-port RAM.
package sdp_pkg;
    typedef enum logic [1:0] {
        PW_AWAKE  = 2'd0,
        PW_ASLEEP = 2'd1,
        PW_WAKING = 2'd2
    } pw_state_e;

    typedef enum logic {
        PRIO_RESET  = 1'b0,
        PRIO_ENABLE = 1'b1
    } oreg_prio_e;

    function automatic bit width_ok(input int w);
        return (w == 0) || (w == 1) || (w == 2) || (w == 4) ||
               (w == 9) || (w == 18) || (w == 36) || (w == 72);
    endfunction
endpackage

// File: rtl/sdp_sleep_ctrl.sv
// Power-state sequencer and access gate.
// Decides on each edge whether the port enables are honoured.
// It tracks awake / asleep / waking and raises the sticky violation flag.
// Assumes sleep is synchronous to clk.
module sdp_sleep_ctrl
    import sdp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic wr_en,
    input  logic rd_en,
    output logic wr_go,
    output logic rd_go,
    output logic awake,
    output logic asleep,
    output logic proto_err
);
    pw_state_e state_q, state_d;
    logic      en_seen_q;
    logic      err_q;
    logic      open_gate;
    logic      violation;

    // Gate enables and detect protocol misuse.
    always_comb begin
        awake     = (state_q == PW_AWAKE);
        asleep    = (state_q == PW_ASLEEP);
        open_gate = awake && !sleep;
        wr_go     = wr_en && open_gate;
        rd_go     = rd_en && open_gate;
        violation = ((wr_en || rd_en) && !open_gate) ||
                    (sleep && awake && en_seen_q);
    end

    // Next power state: sleep wins, then two wake-up steps.
    always_comb begin
        state_d = state_q;
        if (sleep)                       state_d = PW_ASLEEP;
        else if (state_q == PW_ASLEEP)   state_d = PW_WAKING;
        else if (state_q == PW_WAKING)   state_d = PW_AWAKE;
    end

    // State, previous-enable and sticky flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= PW_AWAKE;
            en_seen_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            state_q   <= state_d;
            en_seen_q <= wr_en || rd_en;
            err_q     <= err_q || violation;
        end
    end

    assign proto_err = err_q;
endmodule

// File: rtl/sdp_array.sv
// Storage array with a read-first read latch.
// Contents are not reset. The latch resets to RST_VAL.
// Assumes DEPTH is a power of two.
module sdp_array #(
    parameter int              DW      = 36,
    parameter int              DEPTH   = 512,
    parameter logic [DW-1:0]   RST_VAL = '0,
    localparam int             AW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_go,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_go,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_q
);
    logic [DW-1:0] mem [DEPTH];

    // Write port: store the word on an accepted write.
    always_ff @(posedge clk) begin
        if (wr_go) mem[wr_addr] <= wr_data;
    end

    // Read latch: capture the pre-write word on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= RST_VAL;
        else if (rd_go) rd_q <= mem[rd_addr];
    end
endmodule

// File: rtl/sdp_out_stage.sv
// Optional output pipeline register with selectable clear/enable precedence.
// With OUT_REG = 0 the latch passes straight through, and ce/srst have no effect.
module sdp_out_stage
    import sdp_pkg::*;
#(
    parameter int             DW      = 36,
    parameter bit             OUT_REG = 1'b1,
    parameter oreg_prio_e     PRIO    = PRIO_RESET,
    parameter logic [DW-1:0]  RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          srst,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    if (!OUT_REG) begin : g_bypass
        logic unused_bypass;
        assign unused_bypass = ^{clk, rst_n, ce, srst};
        assign dout = din;
    end else if (PRIO == PRIO_RESET) begin : g_clear_first
        logic [DW-1:0] q;
        // Pipeline register: clear overrides enable.
        always_ff @(posedge clk) begin
            if (!rst_n)    q <= RST_VAL;
            else if (srst) q <= RST_VAL;
            else if (ce)   q <= din;
        end
        assign dout = q;
    end else begin : g_enable_first
        logic [DW-1:0] q;
        // Pipeline register: clear acts only when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n)  q <= RST_VAL;
            else if (ce) q <= srst ? RST_VAL : din;
        end
        assign dout = q;
    end
endmodule

// File: rtl/sdp_sleep_ram.sv
// Top level: write port A, read port B, sleep lockout, optional output register.
// RD_WIDTH = 0 leaves the read port unused. The data path is then one bit
// and rd_data is held low.
module sdp_sleep_ram
    import sdp_pkg::*;
#(
    parameter int          RD_WIDTH = 36,
    parameter int          DEPTH    = 512,
    parameter bit          OUT_REG  = 1'b1,
    parameter oreg_prio_e  RST_PRIO = PRIO_RESET,
    parameter logic [71:0] RST_VAL  = '0,
    localparam int         DW       = (RD_WIDTH == 0) ? 1 : RD_WIDTH,
    localparam int         AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          oreg_ce,
    input  logic          oreg_rst,
    output logic [DW-1:0] rd_data,
    output logic          proto_err
);
    localparam logic [DW-1:0] RV = RST_VAL[DW-1:0];

    logic          wr_go, rd_go;
    logic          pw_awake, pw_asleep;
    logic [DW-1:0] rd_lat, out_q;

    sdp_sleep_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wr_go     (wr_go),
        .rd_go     (rd_go),
        .awake     (pw_awake),
        .asleep    (pw_asleep),
        .proto_err (proto_err)
    );

    sdp_array #(.DW(DW), .DEPTH(DEPTH), .RST_VAL(RV)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_go   (rd_go),
        .rd_addr (rd_addr),
        .rd_q    (rd_lat)
    );

    sdp_out_stage #(.DW(DW), .OUT_REG(OUT_REG), .PRIO(RST_PRIO), .RST_VAL(RV)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (oreg_ce),
        .srst  (oreg_rst),
        .din   (rd_lat),
        .dout  (out_q)
    );

    if (RD_WIDTH == 0) begin : g_port_off
        logic unused_out;
        assign unused_out = ^{out_q, pw_awake, pw_asleep};
        assign rd_data = '0;
    end else begin : g_port_on
        logic unused_pw;
        assign unused_pw = ^{pw_awake, pw_asleep};
        assign rd_data = out_q;
    end
endmodule

// File: rtl/sdp_sleep_ram_chk.sv
// Property checker bound to sdp_sleep_ram.
module sdp_sleep_ram_chk
    import sdp_pkg::*;
#(
    parameter int          RD_WIDTH = 36,
    parameter int          DW       = 36,
    parameter bit          OUT_REG  = 1'b1,
    parameter oreg_prio_e  RST_PRIO = PRIO_RESET,
    parameter logic [71:0] RST_VAL  = '0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sleep,
    input logic          wr_en,
    input logic          rd_en,
    input logic          oreg_ce,
    input logic          oreg_rst,
    input logic [DW-1:0] rd_data,
    input logic          proto_err,
    input logic          awake,
    input logic          asleep
);
    localparam logic [DW-1:0] RV = RST_VAL[DW-1:0];
    logic unused_chk;
    assign unused_chk = ^{oreg_ce, oreg_rst, rd_en, rd_data, awake};

    // R1
    initial width_param_chk: assert (width_ok(RD_WIDTH));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R10
    err_on_sleep_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && (wr_en || rd_en)) |=> proto_err);

    // R8
    sleep_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> asleep);

    // R9
    wake_not_instant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !sleep) |=> !awake);

    if (RD_WIDTH == 0) begin : g_off
        // R1
        port_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data == '0);
    end else if (!OUT_REG) begin : g_lat
        // R3
        latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_en || sleep || !awake) |=> $stable(rd_data));
    end else if (RST_PRIO == PRIO_RESET) begin : g_clr
        // R5
        clear_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
            oreg_rst |=> (rd_data == RV));
    end else begin : g_ena
        // R6
        enable_first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (oreg_rst && !oreg_ce) |=> $stable(rd_data));
        // R6
        enable_first_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (oreg_rst && oreg_ce) |=> (rd_data == RV));
    end
endmodule

bind sdp_sleep_ram sdp_sleep_ram_chk #(
    .RD_WIDTH (RD_WIDTH),
    .DW       (DW),
    .OUT_REG  (OUT_REG),
    .RST_PRIO (RST_PRIO),
    .RST_VAL  (RST_VAL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep     (sleep),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .oreg_ce   (oreg_ce),
    .oreg_rst  (oreg_rst),
    .rd_data   (rd_data),
    .proto_err (proto_err),
    .awake     (pw_awake),
    .asleep    (pw_asleep)
);

// File: tb/sdp_sleep_ram_bench.sv
`timescale 1ns/1ps
module sdp_sleep_ram_bench;
    import sdp_pkg::*;
    localparam int W = 18, D = 32, AW = 5;
    localparam logic [71:0] RV_A = 72'h2A5A5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, sleep, wr_en, rd_en, oreg_ce, oreg_rst;
    logic [AW-1:0] wa, ra;
    logic [W-1:0]  wd;
    logic [W-1:0]  q_a, q_e, q_n;
    logic [0:0]    q_z;
    logic          err_a, err_e, err_n, err_z;
    int total = 0, bad = 0;
    bit done = 0;

    sdp_sleep_ram #(.RD_WIDTH(W), .DEPTH(D), .OUT_REG(1), .RST_PRIO(PRIO_RESET), .RST_VAL(RV_A))
    u_sdp_sleep_ram (.clk(clk), .rst_n(rst_n), .sleep(sleep), .wr_en(wr_en), .wr_addr(wa),
        .wr_data(wd), .rd_en(rd_en), .rd_addr(ra), .oreg_ce(oreg_ce), .oreg_rst(oreg_rst),
        .rd_data(q_a), .proto_err(err_a));
    sdp_sleep_ram #(.RD_WIDTH(W), .DEPTH(D), .OUT_REG(1), .RST_PRIO(PRIO_ENABLE))
    u_sdp_sleep_ram_ep (.clk(clk), .rst_n(rst_n), .sleep(sleep), .wr_en(wr_en), .wr_addr(wa),
        .wr_data(wd), .rd_en(rd_en), .rd_addr(ra), .oreg_ce(oreg_ce), .oreg_rst(oreg_rst),
        .rd_data(q_e), .proto_err(err_e));
    sdp_sleep_ram #(.RD_WIDTH(W), .DEPTH(D), .OUT_REG(0))
    u_sdp_sleep_ram_nr (.clk(clk), .rst_n(rst_n), .sleep(sleep), .wr_en(wr_en), .wr_addr(wa),
        .wr_data(wd), .rd_en(rd_en), .rd_addr(ra), .oreg_ce(oreg_ce), .oreg_rst(oreg_rst),
        .rd_data(q_n), .proto_err(err_n));
    sdp_sleep_ram #(.RD_WIDTH(0), .DEPTH(D), .OUT_REG(1))
    u_sdp_sleep_ram_w0 (.clk(clk), .rst_n(rst_n), .sleep(sleep), .wr_en(wr_en), .wr_addr(wa),
        .wr_data(wd[0:0]), .rd_en(rd_en), .rd_addr(ra), .oreg_ce(oreg_ce), .oreg_rst(oreg_rst),
        .rd_data(q_z), .proto_err(err_z));

    // Reference model state.
    logic [W-1:0] m_mem [D];
    logic [W-1:0] m_lat_a, m_lat_0, m_oa, m_oe;
    int m_st;          // 0 awake, 1 asleep, 2 waking
    bit m_prev_en, m_err;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        m_lat_a = RV_A[W-1:0]; m_lat_0 = '0;
        m_oa = RV_A[W-1:0];    m_oe = '0;
        m_st = 0; m_prev_en = 0; m_err = 0;
    endfunction

    function automatic void model_step();
        bit open, wg, rg;
        logic [W-1:0] la, l0;
        open = (m_st == 0) && !sleep;
        wg = open && wr_en;
        rg = open && rd_en;
        if (((wr_en || rd_en) && !open) || (sleep && m_st == 0 && m_prev_en)) m_err = 1;
        la = m_lat_a; l0 = m_lat_0;
        if (rg) begin m_lat_a = m_mem[ra]; m_lat_0 = m_mem[ra]; end
        if (wg) m_mem[wa] = wd;
        if (oreg_rst)     m_oa = RV_A[W-1:0];
        else if (oreg_ce) m_oa = la;
        if (oreg_ce) m_oe = oreg_rst ? '0 : l0;
        m_prev_en = wr_en || rd_en;
        if (sleep)          m_st = 1;
        else if (m_st == 1) m_st = 2;
        else if (m_st == 2) m_st = 0;
    endfunction

    // One clock: model follows the edge, outputs sampled at the falling edge.
    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R5 clear-first out", q_a, m_oa);
        chk("R6 enable-first out", q_e, m_oe);
        chk("R3 latch out", q_n, m_lat_0);
        chk("R1 unused port", W'(q_z), '0);
        chk("R10 flag", W'({err_a, err_e, err_n, err_z}), W'({4{m_err}}));
    endtask

    task automatic idle();
        sleep = 0; wr_en = 0; rd_en = 0; oreg_ce = 0; oreg_rst = 0;
    endtask

    task automatic do_reset();
        idle(); rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1; model_reset();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v3, v3b, v7;
        void'($urandom(32'd5150));
        wa = '0; ra = '0; wd = '0;
        do_reset();
        // R2: reset state
        chk("R2 reset out A", q_a, RV_A[W-1:0]);
        chk("R2 reset out E", q_e, '0);
        chk("R2 reset latch", q_n, '0);
        chk("R2 reset flag", W'({err_a, err_e, err_n, err_z}), '0);

        for (int i = 0; i < D; i++) begin
            wr_en = 1; wa = AW'(i); wd = W'(i * 1234 + 7);
            step();
        end
        idle();
        v3 = m_mem[3];

        // R3 / R4: latency of latch and pipeline register
        rd_en = 1; ra = 3; oreg_ce = 1;
        step();
        chk("R3 latch after one edge", q_n, v3);
        chk("R4 register not yet loaded", q_a, RV_A[W-1:0]);
        rd_en = 0;
        step();
        chk("R4 register after two edges", q_a, v3);

        // R7: read-first on collision
        v3b = 18'h1B00D;
        wr_en = 1; wa = 3; wd = v3b; rd_en = 1; ra = 3;
        step();
        chk("R7 old word on collision", q_n, v3);
        wr_en = 0;
        step();
        chk("R7 new word afterwards", q_n, v3b);

        // R8 / R9: clean sleep and wake, contents kept
        idle(); step();
        sleep = 1; repeat (3) step();
        sleep = 0; repeat (2) step();
        rd_en = 1; ra = 3; step();
        chk("R8 contents kept through sleep", q_n, v3b);
        chk("R10 no flag on clean sleep", W'(err_n), '0);
        idle(); step();

        // Random phase with legal sleep sequences
        for (int n = 0; n < 1500; n++) begin
            if ($urandom % 25 == 0) begin
                idle(); step();
                sleep = 1;
                repeat (1 + $urandom % 4) step();
                sleep = 0;
                repeat (2) step();
            end else begin
                wr_en = 1'($urandom); rd_en = 1'($urandom);
                wa = AW'($urandom); ra = AW'($urandom); wd = W'($urandom);
                oreg_ce = ($urandom % 4 != 0); oreg_rst = ($urandom % 8 == 0);
                step();
            end
        end

        // Directed priority corners
        idle(); rd_en = 1; ra = 5; oreg_ce = 1; step(); step();
        rd_en = 0; oreg_rst = 1; oreg_ce = 0;
        step();
        chk("R5 clear without enable", q_a, RV_A[W-1:0]);
        chk("R6 hold without enable", q_e, m_mem[5]);
        oreg_ce = 1; step();
        chk("R6 clear with enable", q_e, '0);

        // R8 / R9 / R10: accesses during sleep and wake are dropped
        idle(); rd_en = 1; ra = 3; step();
        v3 = q_n;
        v7 = m_mem[7];
        idle(); step();
        sleep = 1; wr_en = 1; wa = 3; wd = 18'h3FFFF; rd_en = 1; ra = 7;
        step();
        chk("R8 read ignored asleep", q_n, v3);
        chk("R10 flag set", W'(err_n), 18'd1);
        sleep = 0;
        step();
        chk("R9 first wake edge ignored", q_n, v3);
        step();
        chk("R9 second wake edge ignored", q_n, v3);
        wr_en = 0;
        step();
        chk("R9 third edge accepted", q_n, v7);
        ra = 3; step();
        chk("R8 write during sleep dropped", q_n, v3);
        chk("R10 flag stays set", W'(err_n), 18'd1);

        // R10: enable in the cycle before sleep
        do_reset();
        chk("R2 flag cleared by reset", W'(err_a), '0);
        rd_en = 1; ra = 1; step();
        rd_en = 0; sleep = 1; step();
        chk("R10 enable before sleep", W'(err_e), 18'd1);
        sleep = 0; repeat (2) step();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule